// File: doc/BRIEF.md
# SPI Master with Memory-Mapped Control Registers

This block is a serial peripheral interface master that a host drives through a small word-addressed register port. The host places an outgoing word in a transmit holding register. The block moves that word into a shift register as soon as the shifter is free, then clocks it out most significant bit first in SPI mode 0. On the same clock edges it captures the incoming serial line into a receive data register. Both directions are double-buffered, so the host can stage the next word while the current frame is still on the wire.

Status bits tell the host when the holding register can take a word, when a received word is waiting, when the whole transmit path is idle, and when an overrun has occurred on either side. A new received word always replaces the old one. A transmit write made while the holding register is still full is discarded and flagged. Each status condition has its own interrupt enable, and the interrupt line is the OR of the enabled conditions. A slave-select mask register chooses which active-low select lines frame each transfer. A force bit in the control register holds the selected lines low between frames.

The frame width, the serial clock divider and the number of select lines are parameters. Read data is a combinational function of the address. Read side effects and all writes take effect at the clock edge of the access cycle.

Top module: `spi_host_regs`

## Requirements
- R1: After reset the status register (word 2) reads 0x060 (tx-ready bit 6 and idle bit 5 set, all others 0), all select lines are high, SCLK is low and the interrupt output is low.
- R2: A write to word 1 while the holding register is empty stores the low DATA_W bits and clears tx-ready (bit 6) on the next cycle. When the shifter is idle, the word moves into the shifter one cycle later and tx-ready returns to 1.
- R3: A write to word 1 while tx-ready is 0 sets tx-overrun (status bit 4) and leaves the holding register unchanged. The discarded word is never transmitted.
- R4: A frame uses SPI mode 0, MSB first. SCLK idles low and has a period of DIV system clocks (DIV even, at least 2), low for the first half of each bit. MOSI changes only while SCLK is low, and MISO is sampled on each rising SCLK edge. MOSI is 0 while idle.
- R5: When the last bit of a frame has been sampled, the word is placed in word 0 (zero-extended) and rx-ready (status bit 7) is set. A read of word 0 clears rx-ready.
- R6: If rx-ready is still 1 (and not being read in that cycle) when a new frame completes, rx-overrun (status bit 3) is set and word 0 takes the new frame.
- R7: Any write to word 2 clears rx-overrun and tx-overrun. Status bit 8 reads as the OR of the two overrun bits.
- R8: Status bit 5 (idle) is 1 exactly when the shifter is not running and the holding register is empty.
- R9: During a frame, each select line whose bit is 1 in word 5 (bits NSS-1:0) is driven low. Between frames the lines are high unless the force bit (word 3, bit 10) is 1, in which case the masked lines stay low.
- R10: The interrupt output is high exactly when some status bit at position 3, 4, 6, 7 or 8 is 1 and the bit at the same position in word 3 is also 1.
- R11: Writes to word 0 and word 4 have no effect. Write data bits outside a register's defined fields are ignored. Word 4 and the undefined bits of every word read as 0.
- R12: If the holding register is refilled during a frame, the next frame starts automatically. The select lines are released for exactly one system clock between the two frames (force bit clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; a read of word 0 clears rx-ready |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address |
| irq | output | 1 | Interrupt request, active high |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slaves |
| spi_miso | input | 1 | Serial data from the slaves |
| spi_cs_n | output | NSS | Active-low slave selects |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a transmit write landing in the very cycle the holding register is moved into the shifter, which must count as an overrun. The other is a frame completing while an unread word still sits in the receive register. The stimulus reaches the first by issuing two transmit writes on consecutive cycles from idle, and reaches the second by leaving back-to-back frames unread. With loopback from MOSI to MISO, the received word shows which of the staged words actually went out. A behavioural reference model, counting frame time in absolute clock offsets, is compared against every output and the addressed register on every cycle. Random MISO streams are used as well as loopback.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;

    localparam int ADDR_W = 3;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_RXD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_TXD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
    localparam logic [ADDR_W-1:0] A_RSVD = 3'd4;
    localparam logic [ADDR_W-1:0] A_SEL  = 3'd5;

    // bit positions shared by status and control words
    localparam int B_RXOVF = 3;
    localparam int B_TXOVF = 4;
    localparam int B_IDLE  = 5;
    localparam int B_TXRDY = 6;
    localparam int B_RXRDY = 7;
    localparam int B_ERR   = 8;
    localparam int B_FORCE = 10;

    // interrupt sources, also used for the matching enables
    typedef struct packed {
        logic rx_ovf;
        logic tx_ovf;
        logic tx_rdy;
        logic rx_rdy;
        logic err;
    } irq_src_t;

endpackage

// File: rtl/spi_host_clkdiv.sv
`timescale 1ns/1ps
module spi_host_clkdiv #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_end
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q, cnt_d;

    assign half_end = run && (cnt_q == CW'(HALF - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run || half_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/spi_host_shifter.sv
`timescale 1ns/1ps
module spi_host_shifter #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [N-1:0] load_i,
    input  logic         half_end_i,
    input  logic         miso_i,
    output logic         busy_o,
    output logic         sclk_o,
    output logic         mosi_o,
    output logic         done_o,
    output logic [N-1:0] frame_o
);
    localparam int BW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic          busy;
        logic          sclk;
        logic [BW-1:0] bit_idx;
        logic [N-1:0]  tx_sh;
        logic [N-1:0]  rx_sh;
    } sh_t;

    sh_t  sh_q, sh_d;
    logic done_d;
    logic [N:0] rx_ext;

    assign rx_ext = {sh_q.rx_sh, miso_i};

    always_comb begin
        sh_d   = sh_q;
        done_d = 1'b0;
        if (!sh_q.busy) begin
            if (start_i) begin
                sh_d.busy    = 1'b1;
                sh_d.sclk    = 1'b0;
                sh_d.bit_idx = '0;
                sh_d.tx_sh   = load_i;
            end
        end else if (half_end_i) begin
            if (!sh_q.sclk) begin
                // rising edge: capture the incoming bit
                sh_d.sclk  = 1'b1;
                sh_d.rx_sh = rx_ext[N-1:0];
            end else begin
                // falling edge: advance or finish
                sh_d.sclk = 1'b0;
                if (sh_q.bit_idx == BW'(N - 1)) begin
                    sh_d.busy = 1'b0;
                    done_d    = 1'b1;
                end else begin
                    sh_d.bit_idx = sh_q.bit_idx + 1'b1;
                    sh_d.tx_sh   = sh_q.tx_sh << 1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign busy_o  = sh_q.busy;
    assign sclk_o  = sh_q.sclk;
    assign mosi_o  = sh_q.busy & sh_q.tx_sh[N-1];
    assign done_o  = done_d;
    assign frame_o = sh_q.rx_sh;
endmodule

// File: rtl/spi_host_irq.sv
`timescale 1ns/1ps
module spi_host_irq
    import spi_host_pkg::*;
(
    input  irq_src_t src,
    input  irq_src_t en,
    output logic     irq
);
    assign irq = |(src & en);
endmodule

// File: rtl/spi_host_regs.sv
`timescale 1ns/1ps
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV    = 4,
    parameter int NSS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NSS-1:0]    spi_cs_n
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              hold_full;
        logic [DATA_W-1:0] rxd;
        logic              rx_rdy;
        logic              rx_ovf;
        logic              tx_ovf;
        irq_src_t          en;
        logic              sso;
        logic [NSS-1:0]    sel;
    } regs_t;

    regs_t r_q, r_d;

    logic              sh_busy;
    logic              sh_done;
    logic [DATA_W-1:0] sh_frame;
    logic              half_end;
    logic              start;
    logic              wr_txd, wr_stat, wr_ctrl, wr_sel, rd_rxd;
    logic [31:0]       status_w, ctrl_w;
    irq_src_t          src;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;

    assign start   = r_q.hold_full && !sh_busy;
    assign wr_txd  = reg_wr && (reg_addr == A_TXD);
    assign wr_stat = reg_wr && (reg_addr == A_STAT);
    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_sel  = reg_wr && (reg_addr == A_SEL);
    assign rd_rxd  = reg_rd && (reg_addr == A_RXD);

    spi_host_clkdiv #(.DIV(DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (sh_busy),
        .half_end (half_end)
    );

    spi_host_shifter #(.N(DATA_W)) u_sh (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .load_i     (r_q.hold),
        .half_end_i (half_end),
        .miso_i     (spi_miso),
        .busy_o     (sh_busy),
        .sclk_o     (spi_sclk),
        .mosi_o     (spi_mosi),
        .done_o     (sh_done),
        .frame_o    (sh_frame)
    );

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.hold_full = 1'b0;
        end
        if (wr_txd) begin
            if (r_q.hold_full) begin
                r_d.tx_ovf = 1'b1;
            end else begin
                r_d.hold      = reg_wdata[DATA_W-1:0];
                r_d.hold_full = 1'b1;
            end
        end
        if (wr_stat) begin
            r_d.rx_ovf = 1'b0;
            r_d.tx_ovf = 1'b0;
        end
        if (rd_rxd) begin
            r_d.rx_rdy = 1'b0;
        end
        if (sh_done) begin
            r_d.rxd    = sh_frame;
            r_d.rx_rdy = 1'b1;
            if (r_q.rx_rdy && !rd_rxd) begin
                r_d.rx_ovf = 1'b1;
            end
        end
        if (wr_ctrl) begin
            r_d.en.rx_ovf = reg_wdata[B_RXOVF];
            r_d.en.tx_ovf = reg_wdata[B_TXOVF];
            r_d.en.tx_rdy = reg_wdata[B_TXRDY];
            r_d.en.rx_rdy = reg_wdata[B_RXRDY];
            r_d.en.err    = reg_wdata[B_ERR];
            r_d.sso       = reg_wdata[B_FORCE];
        end
        if (wr_sel) begin
            r_d.sel = reg_wdata[NSS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign src.rx_ovf = r_q.rx_ovf;
    assign src.tx_ovf = r_q.tx_ovf;
    assign src.tx_rdy = !r_q.hold_full;
    assign src.rx_rdy = r_q.rx_rdy;
    assign src.err    = r_q.rx_ovf | r_q.tx_ovf;

    always_comb begin
        status_w          = '0;
        status_w[B_RXOVF] = src.rx_ovf;
        status_w[B_TXOVF] = src.tx_ovf;
        status_w[B_IDLE]  = !r_q.hold_full && !sh_busy;
        status_w[B_TXRDY] = src.tx_rdy;
        status_w[B_RXRDY] = src.rx_rdy;
        status_w[B_ERR]   = src.err;
        ctrl_w            = '0;
        ctrl_w[B_RXOVF]   = r_q.en.rx_ovf;
        ctrl_w[B_TXOVF]   = r_q.en.tx_ovf;
        ctrl_w[B_TXRDY]   = r_q.en.tx_rdy;
        ctrl_w[B_RXRDY]   = r_q.en.rx_rdy;
        ctrl_w[B_ERR]     = r_q.en.err;
        ctrl_w[B_FORCE]   = r_q.sso;
    end

    always_comb begin
        unique case (reg_addr)
            A_RXD:   reg_rdata = 32'(r_q.rxd);
            A_STAT:  reg_rdata = status_w;
            A_CTRL:  reg_rdata = ctrl_w;
            A_SEL:   reg_rdata = 32'(r_q.sel);
            default: reg_rdata = '0;
        endcase
    end

    spi_host_irq u_irq (
        .src (src),
        .en  (r_q.en),
        .irq (irq)
    );

    assign spi_cs_n = ~(r_q.sel & {NSS{sh_busy | r_q.sso}});
endmodule

// File: rtl/spi_host_chk.sv
`timescale 1ns/1ps
module spi_host_chk
    import spi_host_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NSS    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              busy,
    input logic              hold_full,
    input logic [DATA_W-1:0] hold,
    input logic              rx_rdy,
    input logic              rx_ovf,
    input logic              tx_ovf,
    input logic              done,
    input logic              sso,
    input irq_src_t          en,
    input logic              irq,
    input logic              sclk,
    input logic [NSS-1:0]    cs_n
);
    // R2: an accepted transmit write fills the holding register
    p_load_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TXD && !hold_full) |=> hold_full);

    // R2: a full holding register with an idle shifter is emptied next cycle
    p_ready_returns_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && !busy) |=> !hold_full);

    // R3: a write while full is flagged and dropped
    p_drop_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TXD && hold_full) |=> (tx_ovf && $stable(hold)));

    // R4: serial clock stays low outside a frame
    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R5: a completed frame raises rx-ready
    p_done_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_rdy);

    // R6: a frame landing on unread data raises rx-overrun
    p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_rdy && !(reg_rd && reg_addr == A_RXD)) |=> rx_ovf);

    // R7: status write clears both overrun flags
    p_stat_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STAT && !done) |=> (!rx_ovf && !tx_ovf));

    // R9: selects released between frames without the force bit
    p_cs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sso) |-> (&cs_n));

    // R10: no interrupt while every enable is clear
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);
endmodule

bind spi_host_regs spi_host_chk #(.DATA_W(DATA_W), .NSS(NSS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .busy      (sh_busy),
    .hold_full (r_q.hold_full),
    .hold      (r_q.hold),
    .rx_rdy    (r_q.rx_rdy),
    .rx_ovf    (r_q.rx_ovf),
    .tx_ovf    (r_q.tx_ovf),
    .done      (sh_done),
    .sso       (r_q.sso),
    .en        (r_q.en),
    .irq       (irq),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n)
);

// File: tb/tb_spi_host_regs.sv
`timescale 1ns/1ps
module tb_spi_host_regs;
    localparam int N     = 8;
    localparam int DIV   = 4;
    localparam int NSS   = 4;
    localparam int HALF  = DIV / 2;
    localparam int DMASK = (1 << N) - 1;
    localparam int SMASK = (1 << NSS) - 1;

    logic           clk   = 1'b0;
    logic           rst_n = 1'b0;
    logic [2:0]     addr  = 3'd2;
    logic           wr    = 1'b0;
    logic           rd    = 1'b0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic           irq, sclk, mosi, miso;
    logic [NSS-1:0] cs_n;

    int    vectors     = 0;
    int    miscompares = 0;
    string cur_req     = "R1";
    logic  lb          = 1'b1;
    logic  [15:0] lfsr = 16'hACE1;

    assign miso = lb ? mosi : lfsr[0];

    always #2.5 clk = ~clk;

    spi_host_regs #(.DATA_W(N), .DIV(DIV), .NSS(NSS)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (addr),
        .reg_wr    (wr),
        .reg_rd    (rd),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq       (irq),
        .spi_sclk  (sclk),
        .spi_mosi  (mosi),
        .spi_miso  (miso),
        .spi_cs_n  (cs_n)
    );

    // ---------------- behavioural reference model ----------------
    // frame timing is tracked as an absolute clock offset m_k from the frame start
    int m_hold, m_full, m_busy, m_k, m_tx, m_acc, m_rxd;
    int m_rrdy, m_rovf, m_tovf, m_ctrl, m_mask;

    function automatic int b2i(input bit c);
        return c ? 1 : 0;
    endfunction

    function automatic int m_status();
        return (b2i(m_rovf != 0) << 3) | (b2i(m_tovf != 0) << 4)
             | (b2i(m_full == 0 && m_busy == 0) << 5) | (b2i(m_full == 0) << 6)
             | (b2i(m_rrdy != 0) << 7) | (b2i(m_rovf != 0 || m_tovf != 0) << 8);
    endfunction

    function automatic logic [31:0] m_rdata(input int a);
        case (a)
            0:       return m_rxd;
            2:       return m_status();
            3:       return m_ctrl;
            5:       return m_mask;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int p_full, p_rrdy, p_done, p_start, p_rd0;
        if (!rst_n) begin
            m_hold = 0; m_full = 0; m_busy = 0; m_k = 0; m_tx = 0; m_acc = 0;
            m_rxd = 0; m_rrdy = 0; m_rovf = 0; m_tovf = 0; m_ctrl = 0; m_mask = 0;
        end else begin
            p_full  = m_full;
            p_rrdy  = m_rrdy;
            p_done  = b2i(m_busy != 0 && m_k == N * DIV - 1);
            p_start = b2i(m_full != 0 && m_busy == 0);
            p_rd0   = b2i(rd && addr == 3'd0);
            if (m_busy != 0 && (m_k % DIV) == HALF - 1)
                m_acc = ((m_acc << 1) | int'(miso)) & DMASK;
            if (p_done != 0) m_busy = 0;
            else if (m_busy != 0) m_k++;
            if (p_start != 0) begin
                m_busy = 1; m_k = 0; m_tx = m_hold; m_full = 0;
            end
            if (wr && addr == 3'd1) begin
                if (p_full != 0) m_tovf = 1;
                else begin m_hold = wdata & DMASK; m_full = 1; end
            end
            if (wr && addr == 3'd2) begin m_rovf = 0; m_tovf = 0; end
            if (p_rd0 != 0) m_rrdy = 0;
            if (p_done != 0) begin
                if (p_rrdy != 0 && p_rd0 == 0) m_rovf = 1;
                m_rrdy = 1;
                m_rxd  = m_acc;
            end
            if (wr && addr == 3'd3) m_ctrl = wdata & 32'h5D8;
            if (wr && addr == 3'd5) m_mask = wdata & SMASK;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int   e_sel;
        logic e_sclk, e_mosi, e_irq;
        e_sclk = (m_busy != 0) && ((m_k % DIV) >= HALF);
        e_mosi = (m_busy != 0) && (((m_tx >> (N - 1 - m_k / DIV)) & 1) != 0);
        e_sel  = (m_busy != 0 || ((m_ctrl >> 10) & 1) != 0) ? m_mask : 0;
        e_irq  = (m_status() & m_ctrl & 32'h1D8) != 0;
        chk("R4 sclk", 32'(sclk), 32'(e_sclk));
        chk("R4 mosi", 32'(mosi), 32'(e_mosi));
        chk("R9 cs_n", 32'(cs_n), 32'((~e_sel) & SMASK));
        chk("R10 irq", 32'(irq), 32'(e_irq));
        chk({cur_req, " rdata"}, rdata, m_rdata(int'(addr)));
    endtask

    task automatic step(input int a, input bit w, input bit r, input logic [31:0] d);
        @(negedge clk);
        compare_all();
        addr  = a[2:0];
        wr    = w;
        rd    = r;
        wdata = d;
        lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(2, 1'b0, 1'b0, '0);
    endtask

    task automatic peek(input int a, input logic [31:0] exp, input string tag);
        step(a, 1'b0, 1'b0, '0);
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic pin_after(input string tag, input logic [31:0] act_unused);
        // placeholder-free helper: advance one idle cycle before a pin check
        step(2, 1'b0, 1'b0, act_unused & 32'h0);
        #1;
        vectors += 0;
        if (tag.len() == 0) miscompares++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cur_req = "R1";
        peek(2, 32'h060, "R1 status after reset");
        chk("R1 cs_n idle", 32'(cs_n), 32'(SMASK));
        chk("R1 sclk idle", 32'(sclk), 0);
        chk("R1 irq idle", 32'(irq), 0);

        // R11 upper write bits of the select mask are ignored
        cur_req = "R11";
        step(5, 1'b1, 1'b0, 32'hFFFF_FFF5);
        peek(5, 32'h5, "R11 select mask upper bits");

        // R2 first frame, loopback
        cur_req = "R2";
        step(1, 1'b1, 1'b0, 32'hFFFF_FFA5);
        peek(2, 32'h000, "R2 tx-ready cleared by write");
        peek(2, 32'h040, "R2 tx-ready back after move");
        chk("R9 cs_n during frame", 32'(cs_n), 32'hA);
        cur_req = "R4";
        idle(36);
        cur_req = "R5";
        peek(0, 32'h0A5, "R5 loopback word");
        peek(2, 32'h0E0, "R5 rx-ready set");
        step(0, 1'b0, 1'b1, '0);
        peek(2, 32'h060, "R5 read clears rx-ready");
        chk("R8 idle bit with empty path", rdata & 32'h20, 32'h20);

        // R3 / R12 overrun on transmit, refill during frame
        cur_req = "R3";
        step(1, 1'b1, 1'b0, 32'h3C);
        step(1, 1'b1, 1'b0, 32'h99);
        cur_req = "R12";
        step(1, 1'b1, 1'b0, 32'h5A);
        cur_req = "R3";
        step(1, 1'b1, 1'b0, 32'h11);
        peek(2, 32'h110, "R3 tx-overrun and error set");
        chk("R8 idle bit low while busy", rdata & 32'h20, 32'h0);
        cur_req = "R12";
        idle(80);
        cur_req = "R6";
        peek(0, 32'h05A, "R6 second frame overwrites, dropped words unsent");
        peek(2, 32'h1F8, "R6 rx-overrun set");

        // R7 status write clears errors
        cur_req = "R7";
        step(2, 1'b1, 1'b0, 32'hFFFF_FFFF);
        peek(2, 32'h0E0, "R7 status write clears overruns");

        // R11 writes with no effect
        cur_req = "R11";
        step(0, 1'b1, 1'b0, 32'h77);
        peek(0, 32'h05A, "R11 rx register write ignored");
        step(4, 1'b1, 1'b0, 32'hFFFF);
        peek(4, 32'h0, "R11 reserved word reads zero");
        peek(3, 32'h0, "R11 control untouched");

        // R10 interrupt
        cur_req = "R10";
        step(3, 1'b1, 1'b0, 32'hFFFF_F880);
        step(2, 1'b0, 1'b0, '0); #1;
        chk("R10 irq from rx-ready", 32'(irq), 1);
        peek(3, 32'h080, "R11 control undefined bits dropped");
        step(0, 1'b0, 1'b1, '0);
        step(2, 1'b0, 1'b0, '0); #1;
        chk("R10 irq drops after read", 32'(irq), 0);
        step(3, 1'b1, 1'b0, 32'h040);
        step(2, 1'b0, 1'b0, '0); #1;
        chk("R10 irq from tx-ready", 32'(irq), 1);
        step(3, 1'b1, 1'b0, 32'h100);
        step(2, 1'b0, 1'b0, '0); #1;
        chk("R10 irq masked error enable", 32'(irq), 0);
        step(1, 1'b1, 1'b0, 32'h12);
        step(1, 1'b1, 1'b0, 32'h34);
        step(2, 1'b0, 1'b0, '0); #1;
        chk("R10 irq from error", 32'(irq), 1);
        idle(40);
        step(2, 1'b1, 1'b0, '0);
        step(2, 1'b0, 1'b0, '0); #1;
        chk("R10 irq cleared with errors", 32'(irq), 0);

        // R9 force bit
        cur_req = "R9";
        step(3, 1'b1, 1'b0, 32'h400);
        step(2, 1'b0, 1'b0, '0); #1;
        chk("R9 forced select low", 32'(cs_n), 32'hA);
        step(5, 1'b1, 1'b0, 32'h3);
        step(2, 1'b0, 1'b0, '0); #1;
        chk("R9 forced with new mask", 32'(cs_n), 32'hC);
        step(3, 1'b1, 1'b0, 32'h0);
        step(2, 1'b0, 1'b0, '0); #1;
        chk("R9 released without force", 32'(cs_n), 32'hF);

        // R5 random MISO frames, read between frames
        cur_req = "R5";
        lb = 1'b0;
        for (int f = 0; f < 6; f++) begin
            step(1, 1'b1, 1'b0, 32'(f * 37 + 11));
            idle(36);
            step(0, 1'b0, 1'b1, '0);
            idle(2);
        end

        // R12 back-to-back with random MISO and force on, no read
        cur_req = "R12";
        step(3, 1'b1, 1'b0, 32'h400);
        step(1, 1'b1, 1'b0, 32'hC3);
        step(2, 1'b0, 1'b0, '0);
        step(1, 1'b1, 1'b0, 32'h81);
        idle(75);
        peek(0, m_rxd, "R12 receive after back-to-back");

        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule